// File: doc/BRIEF.md
# Serial Sampling-Converter Frame and Power-Mode Controller

This block is the digital control side of an 8-bit serial sampling converter, seen from the peripheral. A host drives an active-low chip select and a serial clock. Each chip-select fall starts a frame: the block captures the conversion code, which stands in for the successive-approximation result, and goes from track to hold. It then shifts out a zero-padded 16-bit word in straight binary, one bit per serial-clock falling edge, and later returns to track.

The point within the frame where chip select rises decides the power mode. A very early rise is treated as noise and leaves the mode unchanged. A rise in the middle of the frame sends the block into shutdown. A late rise only cuts the word short. A frame that starts in shutdown powers the block up. Its result is flagged as a dummy, and it only leaves the block in normal mode if chip select stays low through the 10th falling edge. Both inputs are oversampled by a system clock that runs at least four times faster than the serial clock.

Top module: `sadc_frame_ctrl`

## Requirements
- R1: A chip-select fall captures `code_i`, sets `hold_o` to 1 and enables `sdo_oe_o`. Later changes of `code_i` within the same frame do not alter the shifted word.
- R2: Bit k of the frame is the value on `sdo_o` after k serial-clock falls, for k = 0..15. Bits 0..3 are 0. Bits 4..11 are the captured code, MSB first. Bits 12..15 are 0.
- R3: `hold_o` stays 1 through the 12th serial-clock rise of the frame and drops to 0 (track) on the 13th rise. An aborted frame also returns to track.
- R4: `sdo_oe_o` drops to 0 on the 16th serial-clock fall of the frame.
- R5: `sdo_oe_o` drops to 0 when chip select rises, whichever of R4 and R5 occurs first.
- R6: In normal mode, a chip-select rise after fewer than 2 falls leaves `awake_o` at 1.
- R7: In normal mode, a chip-select rise after 2 to 10 falls sets `awake_o` to 0 (shutdown).
- R8: In normal mode, a chip-select rise after 11 to 15 falls aborts the word but leaves `awake_o` at 1.
- R9: A frame that starts with `awake_o` at 0 is a dummy. `awake_o` becomes 1 on its 10th fall. A rise before that fall leaves the block in shutdown.
- R10: `valid_o` becomes 1 on the 16th fall of a frame that is not a dummy, and clears on the next chip-select fall.
- R11: After reset, `awake_o`, `valid_o`, `hold_o`, `sdo_oe_o` and `sdo_o` are all 0.
- R12: The fall counter saturates at 16. Further falls while chip select stays low change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| code_i | input | 8 | Conversion code to be sampled |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Output enable for the serial data bit |
| hold_o | output | 1 | 1 in hold, 0 in track |
| awake_o | output | 1 | 1 in normal mode, 0 in shutdown |
| valid_o | output | 1 | Last completed frame carried a usable result |

## Verification
The assertions assume that chip select and the serial clock each hold their level for several system-clock cycles. They also assume that a chip-select edge never reaches the synchroniser in the same cycle as a serial-clock edge. With those assumptions the decoded edges are single-cycle and never overlap. The stimulus keeps to this. The serial clock idles high, each half period lasts six system-clock cycles, and chip select only moves while the serial clock is high and has been stable for a full half period.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic {
    PWR_DOWN = 1'b0,
    PWR_UP   = 1'b1
  } pwr_e;
endpackage

// File: rtl/sadc_edge_sync.sv
module sadc_edge_sync #(
  parameter int unsigned N = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise_o[i] = sync_q[i] & ~prev_q[i];
    assign fall_o[i] = ~sync_q[i] & prev_q[i];
  end
endmodule

// File: rtl/sadc_frame_cnt.sv
module sadc_frame_cnt #(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned TRACK_RISE = 13,
  localparam int unsigned CNT_W     = $clog2(WORD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  input  logic             sclk_rise_i,
  output logic             in_frame_o,
  output logic [CNT_W-1:0] fall_cnt_o,
  output logic             hold_o
);
  logic [CNT_W-1:0] rise_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_o <= 1'b0;
      fall_cnt_o <= '0;
      rise_cnt_q <= '0;
      hold_o     <= 1'b0;
    end else if (cs_fall_i) begin
      in_frame_o <= 1'b1;
      fall_cnt_o <= '0;
      rise_cnt_q <= '0;
      hold_o     <= 1'b1;
    end else if (cs_rise_i) begin
      in_frame_o <= 1'b0;
      hold_o     <= 1'b0;
    end else if (in_frame_o) begin
      if (sclk_fall_i && fall_cnt_o != CNT_W'(WORD_W))
        fall_cnt_o <= fall_cnt_o + 1'b1;
      if (sclk_rise_i && rise_cnt_q != CNT_W'(TRACK_RISE))
        rise_cnt_q <= rise_cnt_q + 1'b1;
      if (sclk_rise_i && rise_cnt_q == CNT_W'(TRACK_RISE - 1))
        hold_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sadc_shift_out.sv
module sadc_shift_out #(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned PAD_LEAD  = 4,
  parameter int unsigned PAD_TRAIL = 4,
  localparam int unsigned WORD_W   = PAD_LEAD + CODE_W + PAD_TRAIL,
  localparam int unsigned CNT_W    = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sclk_fall_i,
  input  logic              in_frame_i,
  input  logic [CNT_W-1:0]  fall_cnt_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              sdo_o,
  output logic              oe_o
);
  logic [WORD_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      oe_o   <= 1'b0;
    end else if (cs_fall_i) begin
      sreg_q <= {{PAD_LEAD{1'b0}}, code_i, {PAD_TRAIL{1'b0}}};
      oe_o   <= 1'b1;
    end else if (cs_rise_i) begin
      oe_o <= 1'b0;
    end else if (in_frame_i && sclk_fall_i) begin
      sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      if (fall_cnt_i == CNT_W'(WORD_W - 1))
        oe_o <= 1'b0;
    end
  end

  assign sdo_o = oe_o & sreg_q[WORD_W-1];
endmodule

// File: rtl/sadc_mode_ctl.sv
module sadc_mode_ctl #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned GUARD_FALLS = 2,
  parameter int unsigned SLEEP_LAST  = 10,
  localparam int unsigned CNT_W      = $clog2(WORD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  input  logic             in_frame_i,
  input  logic [CNT_W-1:0] fall_cnt_i,
  output logic             awake_o,
  output logic             valid_o
);
  import sadc_pkg::*;
  pwr_e pwr_q;
  logic dummy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q   <= PWR_DOWN;
      dummy_q <= 1'b1;
      valid_o <= 1'b0;
    end else if (cs_fall_i) begin
      dummy_q <= (pwr_q == PWR_DOWN);
      valid_o <= 1'b0;
    end else if (cs_rise_i && in_frame_i) begin
      // window rule only applies to frames that started powered
      if (!dummy_q && fall_cnt_i >= CNT_W'(GUARD_FALLS) &&
          fall_cnt_i <= CNT_W'(SLEEP_LAST))
        pwr_q <= PWR_DOWN;
    end else if (sclk_fall_i && in_frame_i) begin
      if (dummy_q && fall_cnt_i == CNT_W'(SLEEP_LAST - 1))
        pwr_q <= PWR_UP;
      if (!dummy_q && fall_cnt_i == CNT_W'(WORD_W - 1))
        valid_o <= 1'b1;
    end
  end

  assign awake_o = (pwr_q == PWR_UP);
endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl #(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned PAD_LEAD    = 4,
  parameter int unsigned PAD_TRAIL   = 4,
  parameter int unsigned TRACK_RISE  = 13,
  parameter int unsigned GUARD_FALLS = 2,
  parameter int unsigned SLEEP_LAST  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              hold_o,
  output logic              awake_o,
  output logic              valid_o
);
  localparam int unsigned WORD_W = PAD_LEAD + CODE_W + PAD_TRAIL;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  logic [1:0] rise_w, fall_w;
  logic cs_fall, cs_rise, sclk_fall, sclk_rise, in_frame;
  logic [CNT_W-1:0] fall_cnt;

  // bit 1 = chip select, bit 0 = serial clock; both idle high
  sadc_edge_sync #(.N(2), .RST_VAL(2'b11)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({cs_ni, sclk_i}),
    .rise_o(rise_w), .fall_o(fall_w)
  );
  assign cs_fall   = fall_w[1];
  assign cs_rise   = rise_w[1];
  assign sclk_fall = fall_w[0];
  assign sclk_rise = rise_w[0];

  sadc_frame_cnt #(.WORD_W(WORD_W), .TRACK_RISE(TRACK_RISE)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise),
    .in_frame_o(in_frame), .fall_cnt_o(fall_cnt), .hold_o(hold_o)
  );

  sadc_shift_out #(.CODE_W(CODE_W), .PAD_LEAD(PAD_LEAD), .PAD_TRAIL(PAD_TRAIL)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_fall_i(sclk_fall), .in_frame_i(in_frame), .fall_cnt_i(fall_cnt),
    .code_i(code_i), .sdo_o(sdo_o), .oe_o(sdo_oe_o)
  );

  sadc_mode_ctl #(.WORD_W(WORD_W), .GUARD_FALLS(GUARD_FALLS), .SLEEP_LAST(SLEEP_LAST)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_fall_i(sclk_fall), .in_frame_i(in_frame), .fall_cnt_i(fall_cnt),
    .awake_o(awake_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/sadc_frame_ctrl_chk.sv
module sadc_frame_ctrl_chk #(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned WORD_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_fall,
  input logic             cs_rise,
  input logic             sclk_rise,
  input logic [CNT_W-1:0] fall_cnt,
  input logic             hold_o,
  input logic             sdo_oe_o,
  input logic             awake_o,
  input logic             valid_o
);
  a_r1_frame_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> hold_o && sdo_oe_o);

  a_r5_oe_off_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> !sdo_oe_o);

  a_r3_track_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $past(sclk_rise || cs_rise));

  a_r10_valid_needs_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> awake_o);

  a_r12_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_cnt <= CNT_W'(WORD_W));

  a_r10_valid_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> !valid_o);
endmodule

bind sadc_frame_ctrl sadc_frame_ctrl_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .sclk_rise(sclk_rise), .fall_cnt(fall_cnt), .hold_o(hold_o),
  .sdo_oe_o(sdo_oe_o), .awake_o(awake_o), .valid_o(valid_o)
);

// File: tb/sadc_frame_ctrl_test.sv
`timescale 1ns/1ps
module sadc_frame_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic [7:0] code = 8'h00;
  logic sdo, sdo_oe, hold, awake, valid;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sadc_frame_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .code_i(code),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .hold_o(hold), .awake_o(awake), .valid_o(valid)
  );

  // {code, falls before chip-select rise, expected awake, expected valid}
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {8'hA5, 5'd16, 1'b1, 1'b0},  // R9 dummy wake frame
    {8'h3C, 5'd16, 1'b1, 1'b1},  // R10
    {8'hFF, 5'd12, 1'b1, 1'b0},  // R8
    {8'h00, 5'd1,  1'b1, 1'b0},  // R6
    {8'h81, 5'd16, 1'b1, 1'b1},
    {8'h55, 5'd5,  1'b0, 1'b0},  // R7
    {8'h7E, 5'd9,  1'b0, 1'b0},  // R9 early rise
    {8'hC3, 5'd16, 1'b1, 1'b0},  // R9
    {8'h01, 5'd16, 1'b1, 1'b1},
    {8'h99, 5'd2,  1'b0, 1'b0},  // R7 lower edge
    {8'h22, 5'd10, 1'b1, 1'b0},  // R9 at 10th fall
    {8'h44, 5'd10, 1'b0, 1'b0},  // R7 upper edge
    {8'h6B, 5'd0,  1'b0, 1'b0},  // R9 no falls
    {8'h3C, 5'd16, 1'b1, 1'b0},
    {8'hE7, 5'd11, 1'b1, 1'b0},  // R8 lower edge
    {8'h5A, 5'd16, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (6) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] c, input int nf, input bit ex_awake, input bit ex_valid);
    logic [15:0] got;
    logic [15:0] want;
    got = '0;
    want = {4'b0000, c, 4'b0000};
    code = c;
    cs_n = 1'b0;
    wait_half();
    chk(hold === 1'b1, "R1 hold", hold, 1);
    chk(sdo_oe === 1'b1, "R1 oe", sdo_oe, 1);
    got[15] = sdo;
    code = ~c;  // R1: must not reach the word
    for (int k = 1; k <= nf; k++) begin
      sclk = 1'b0;
      wait_half();
      if (k < 16) got[15-k] = sdo;
      if (k == 15) chk(sdo_oe === 1'b1, "R4 oe before end", sdo_oe, 1);
      if (k == 16) chk(sdo_oe === 1'b0, "R4 oe after 16th", sdo_oe, 0);
      if (k > 16) chk(sdo_oe === 1'b0 && sdo === 1'b0, "R12 extra fall", {sdo_oe, sdo}, 0);
      sclk = 1'b1;
      wait_half();
      if (k == 12) chk(hold === 1'b1, "R3 hold at 12", hold, 1);
      if (k == 13) chk(hold === 1'b0, "R3 track at 13", hold, 0);
    end
    cs_n = 1'b1;
    wait_half();
    chk(sdo_oe === 1'b0, "R5 oe after rise", sdo_oe, 0);
    chk(hold === 1'b0, "R3 track after frame", hold, 0);
    if (nf >= 16) chk(got === want, "R2 word", got, want);
    chk(awake === ex_awake, "mode R6 R7 R8 R9", awake, ex_awake);
    chk(valid === ex_valid, "R10 valid", valid, ex_valid);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({awake, valid, hold, sdo_oe, sdo} === 5'b0, "R11 reset", {awake, valid, hold, sdo_oe, sdo}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({awake, valid, hold, sdo_oe, sdo} === 5'b0, "R11 after release", {awake, valid, hold, sdo_oe, sdo}, 0);
    for (int i = 0; i < NV; i++)
      run_frame(VEC[i][14:7], int'(VEC[i][6:2]), VEC[i][1], VEC[i][0]);
    // R12: falls beyond 16 with chip select still low
    run_frame(8'hB4, 18, 1'b1, 1'b1);
    // R11: reset mid-frame returns to shutdown
    code = 8'h0F;
    cs_n = 1'b0;
    wait_half();
    rst_n = 1'b0;
    @(negedge clk);
    chk({awake, valid, hold, sdo_oe} === 4'b0, "R11 reset mid-frame", {awake, valid, hold, sdo_oe}, 0);
    cs_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    run_frame(8'hC6, 16, 1'b1, 1'b0);  // R9 after reset: dummy
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule